// File: doc/BRIEF.md
# Reset Cause and Watchdog Status Register

This block keeps an 8-bit status word that firmware reads after a reset to learn why the reset happened. A power-on reset and a watchdog timeout each leave their own flag in the word. A watchdog reset sets its own flag and leaves the power-on and bus-reset flags as they were, so the two causes stay distinguishable. The word also holds a sticky flag for a bus-reset event. It carries two read-only mirrors: one shows whether an interrupt is pending and one shows the processor's global interrupt enable.

A watchdog counter advances on each pulse of a slow tick input, nominally 1 kHz. Firmware restarts it with a kick strobe. If the count reaches a parameterised number of ticks without a kick, the block raises a one-cycle watchdog reset request. In the same step it marks the status word as a watchdog reset. Firmware clears the sticky flags by writing zeros to their bit positions.

Top module: `rc_reset_cause`

## Requirements
- R1: While `rst_n` is low at a clock edge (power-on reset), `status_o` becomes 8'h11: bit 4 (power-on flag) and bit 0 (run bit, always 1) are set, and every other bit is clear. `wdt_rst_o` is 0 and the watchdog count restarts from zero.
- R2: If `TIMEOUT_TICKS` tick pulses arrive with no kick since the last reset or kick, `wdt_rst_o` is high for exactly one cycle. That cycle is the one after the edge that registers the last of those ticks.
- R3: A `wdt_kick_i` pulse restarts the count from zero. A kick in the same cycle as a tick wins, and that tick is not counted.
- R4: The cycle after `wdt_rst_o` is high, bit 6 (watchdog flag) is set and bits 7 and 2 are clear. Bits 5 and 4 keep their earlier values, bit 0 is 1, and bits 3 and 1 are 0.
- R5: A `bus_rst_i` pulse sets bit 5 (bus-reset flag) at the next edge. The bit stays set until firmware clears it.
- R6: Bit 7 shows `irq_pend_i` as registered at the previous edge.
- R7: Bit 2 shows `gie_i` as registered at the previous edge.
- R8: A write (`wr_en_i` high) with a 0 in bit 6, 5 or 4 of `wr_data_i` clears that flag. A 1 there leaves it unchanged and never sets it. Written values in bits 7, 3, 2, 1 and 0 have no effect.
- R9: When a bus-reset pulse and a write that clears bit 5 fall in the same cycle, bit 5 ends up set.
- R10: After a watchdog reset the count starts again from zero, so the next request needs another full `TIMEOUT_TICKS` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick_i | input | 1 | One-cycle pulse of the slow watchdog time base |
| wdt_kick_i | input | 1 | Firmware watchdog restart strobe |
| bus_rst_i | input | 1 | One-cycle pulse marking a detected bus reset |
| irq_pend_i | input | 1 | High while any interrupt is pending |
| gie_i | input | 1 | Processor global interrupt enable state |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 8 | Data for a status register write |
| status_o | output | 8 | Status word |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with `TIMEOUT_TICKS` set to 4 rather than the default 8. This lets it walk each timeout edge tick by tick and still hit it exactly. The short timeout also brings into reach a second consecutive timeout, which checks the restart, and a kick that lands in the same cycle as a tick. Each test drives its ticks one at a time, so the exact cycle of the request and of the watchdog flag is known beforehand.

// File: rtl/rc_pkg.sv
// Shared bit positions, reset value and flag record for the reset-cause block.
package rc_pkg;
    localparam int BIT_IRQ = 7;
    localparam int BIT_WDR = 6;
    localparam int BIT_BUS = 5;
    localparam int BIT_POR = 4;
    localparam int BIT_GIE = 2;

    typedef struct packed {
        logic irq;
        logic wdr;
        logic bus;
        logic por;
        logic gie;
    } rc_flags_t;

    localparam rc_flags_t FLAGS_POR = '{irq: 1'b0, wdr: 1'b0, bus: 1'b0, por: 1'b1, gie: 1'b0};
endpackage

// File: rtl/rc_wdt.sv
// Watchdog counter. It counts time-base ticks and raises a one-cycle fire
// pulse when TIMEOUT_TICKS ticks pass with no kick.
// Assumes: tick is a single-cycle pulse and TIMEOUT_TICKS >= 1.
module rc_wdt #(
    parameter int TIMEOUT_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick,
    output logic fire
);
    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          fire_q;

    // Advance, restart or expire the count; a kick beats a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (fire_q || kick) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    fire_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign fire = fire_q;

    // R2
    fire_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);

    // R3
    kick_blocks_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !fire_q);

    // R10
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/rc_status_reg.sv
// Status word holding the reset-cause flags, the sticky bus-reset flag and
// registered mirrors of the pending-interrupt and global-enable inputs.
// Assumes: wdt_fire is a one-cycle pulse from the watchdog.
module rc_status_reg
    import rc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wdt_fire,
    input  logic       bus_evt,
    input  logic       irq_in,
    input  logic       gie_in,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] status
);
    rc_flags_t flags_q;
    logic      clr_wdr, clr_bus, clr_por;

    // Write-zero-to-clear decode for the sticky flags.
    always_comb begin
        clr_wdr = wr_en && !wr_data[BIT_WDR];
        clr_bus = wr_en && !wr_data[BIT_BUS];
        clr_por = wr_en && !wr_data[BIT_POR];
    end

    // Update flags: power-on first, then watchdog reset, then normal run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= FLAGS_POR;
        end else if (wdt_fire) begin
            flags_q.irq <= 1'b0;
            flags_q.gie <= 1'b0;
            flags_q.wdr <= 1'b1;
            flags_q.bus <= flags_q.bus || bus_evt;
        end else begin
            flags_q.irq <= irq_in;
            flags_q.gie <= gie_in;
            flags_q.wdr <= flags_q.wdr && !clr_wdr;
            flags_q.por <= flags_q.por && !clr_por;
            flags_q.bus <= bus_evt || (flags_q.bus && !clr_bus);
        end
    end

    // Pack the flags into the status word.
    assign status = {flags_q.irq, flags_q.wdr, flags_q.bus, flags_q.por,
                     1'b0, flags_q.gie, 1'b0, 1'b1};

    // R4
    wdr_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fire |=> status[BIT_WDR] && !status[BIT_IRQ] && !status[BIT_GIE]);

    // R4
    wdr_keeps_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fire |=> status[BIT_POR] == $past(status[BIT_POR]));

    // R5
    bus_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_evt |=> status[BIT_BUS]);

    // R8
    por_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(status[BIT_POR]));

    // R8
    wdr_rise_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[BIT_WDR]) |-> $past(wdt_fire));
endmodule

// File: rtl/rc_reset_cause.sv
// Top of the reset-cause block: a watchdog counter feeding the status word.
// Assumes: rst_n is the synchronous power-on reset; the watchdog request is
// returned to the system, and this block records it on its own.
module rc_reset_cause #(
    parameter int TIMEOUT_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wdt_kick_i,
    input  logic       bus_rst_i,
    input  logic       irq_pend_i,
    input  logic       gie_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] status_o,
    output logic       wdt_rst_o
);
    logic fire;

    rc_wdt #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_wdt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_i),
        .kick  (wdt_kick_i),
        .fire  (fire)
    );

    rc_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdt_fire (fire),
        .bus_evt  (bus_rst_i),
        .irq_in   (irq_pend_i),
        .gie_in   (gie_i),
        .wr_en    (wr_en_i),
        .wr_data  (wr_data_i),
        .status   (status_o)
    );

    assign wdt_rst_o = fire;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !wdt_rst_o);
endmodule

// File: tb/tb_rc_reset_cause.sv
module tb_rc_reset_cause;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, wdt_kick_i = 1'b0, bus_rst_i = 1'b0;
    logic       irq_pend_i = 1'b0, gie_i = 1'b0, wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] status_o;
    logic       wdt_rst_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    rc_reset_cause #(.TIMEOUT_TICKS(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wdt_kick_i(wdt_kick_i),
        .bus_rst_i(bus_rst_i), .irq_pend_i(irq_pend_i), .gie_i(gie_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .status_o(status_o), .wdt_rst_o(wdt_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tick();
        tick_i = 1'b1; step(); tick_i = 1'b0;
    endtask

    task automatic kick();
        wdt_kick_i = 1'b1; step(); wdt_kick_i = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en_i = 1'b1; wr_data_i = d; step(); wr_en_i = 1'b0;
    endtask

    task automatic do_por();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    endtask

    // R1: reset value, even with mirrors driven high during reset
    task automatic t_por();
        irq_pend_i = 1'b1; gie_i = 1'b1;
        rst_n = 1'b0; step(); step();
        check("R1 status", status_o, 8'h11);
        check("R1 wdt_rst", {7'd0, wdt_rst_o}, 8'h00);
        irq_pend_i = 1'b0; gie_i = 1'b0;
        rst_n = 1'b1; step();
        check("R1 after release", status_o, 8'h11);
    endtask

    // R2, R4, R10: timeout edge, flag update, restart
    task automatic t_timeout();
        kick();
        for (int i = 0; i < TMO - 1; i++) tick();
        check("R2 no early fire", {7'd0, wdt_rst_o}, 8'h00);
        tick();
        check("R2 fire", {7'd0, wdt_rst_o}, 8'h01);
        step();
        check("R2 one cycle", {7'd0, wdt_rst_o}, 8'h00);
        check("R4 status after wdt", status_o, 8'h51);
        for (int i = 0; i < TMO - 1; i++) tick();
        check("R10 no early refire", {7'd0, wdt_rst_o}, 8'h00);
        tick();
        check("R10 refire", {7'd0, wdt_rst_o}, 8'h01);
        step();
    endtask

    // R3: kick restarts; kick beats a simultaneous tick
    task automatic t_kick();
        do_por();
        for (int i = 0; i < TMO - 1; i++) tick();
        tick_i = 1'b1; wdt_kick_i = 1'b1; step(); tick_i = 1'b0; wdt_kick_i = 1'b0;
        for (int i = 0; i < TMO - 1; i++) tick();
        check("R3 kick restarts", {7'd0, wdt_rst_o}, 8'h00);
        tick();
        check("R3 fire after full count", {7'd0, wdt_rst_o}, 8'h01);
        step();
    endtask

    // R5, R6, R7, R4: bus flag, mirrors, watchdog clearing mirrors
    task automatic t_flags();
        do_por();
        bus_rst_i = 1'b1; step(); bus_rst_i = 1'b0;
        check("R5 bus flag", status_o, 8'h31);
        step();
        check("R5 bus sticky", status_o, 8'h31);
        irq_pend_i = 1'b1; step();
        check("R6 irq mirror", status_o, 8'hB1);
        gie_i = 1'b1; step();
        check("R7 gie mirror", status_o, 8'hB5);
        kick();
        for (int i = 0; i < TMO; i++) tick();
        step();
        check("R4 wdt keeps 5,4 clears 7,2", status_o, 8'h71);
        step();
        check("R6 R7 mirrors resume", status_o, 8'hF5);
        irq_pend_i = 1'b0; gie_i = 1'b0; step();
        check("R6 R7 mirrors drop", status_o, 8'h71);
    endtask

    // R8, R9: write-zero-to-clear, ones ignored, event beats clear
    task automatic t_write();
        wr(8'hFF);
        check("R8 ones no effect", status_o, 8'h71);
        wr(8'hBF);
        check("R8 clear wdr", status_o, 8'h31);
        wr(8'h00);
        check("R8 clear all", status_o, 8'h01);
        wr(8'hFF);
        check("R8 ones do not set", status_o, 8'h01);
        bus_rst_i = 1'b1; wr(8'h00); bus_rst_i = 1'b0;
        check("R9 event beats clear", status_o, 8'h21);
    endtask

    initial begin
        step();
        t_por();
        t_timeout();
        t_kick();
        t_flags();
        t_write();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule